// File: doc/BRIEF.md
# Address-Space-Tagged Fully Associative Translation Buffer

This block holds a small set of page translations. Each one is keyed by a virtual page number and owned either by one address space or by all of them. A requester gives a virtual page number and the current address-space number. In the same cycle it gets back a hit flag, the slot index and the stored fields of the matching entry: physical page number, owner address-space number and global flag. Pages are 8 KB, so the page number is the virtual address from bit 13 upward.

New translations go into the slot named by a rolling next-to-use pointer. Whatever that slot held is overwritten. Three invalidation commands each take one clock edge:
- clear everything;
- clear every entry not marked global;
- clear the entries of one page under the same ownership rule that lookups use.

A separate command can step the pointer without writing anything, and the pointer value is always visible.

At most one state-changing operation takes effect per cycle. Typical depths are 48 slots for an instruction-side buffer and 64 slots for a data-side one.

Top module: `tlb_assoc`

## Requirements
- R1: A slot matches a lookup only when it is valid, its stored page number equals `lk_vpn`, and either its global flag is 1 or its stored address-space number equals `lk_asn`. `lk_hit` is 1 exactly when some slot matches.
- R2: When several slots match, the lowest slot index is reported on `lk_idx`, with that slot's `lk_ppn`, `lk_asn` and `lk_global`. On a miss, `lk_idx`, `lk_ppn`, `lk_asn` and `lk_global` are all 0.
- R3: An insert writes the slot at the pointer with tag `ins_vaddr[13 +: VPN_W]` and the supplied fields, marks it valid, and advances the pointer. The pointer wraps from DEPTH-1 to 0.
- R4: Flush-all makes every slot invalid and sets the pointer to 0.
- R5: Flush-process makes every slot with global flag 0 invalid. Global slots and the pointer are unchanged.
- R6: Flush-page makes invalid every slot that would match a lookup of `fl_vpn` under `fl_asn`. All other slots and the pointer are unchanged.
- R7: `nxt_idx` always shows the pointer. `nxt_adv` advances it by one with wrap and writes no slot.
- R8: Only one operation takes effect per clock. The priority is flush-all, then flush-process, then flush-page, then insert, then advance. Lower-priority requests in the same cycle are ignored.
- R9: After reset every slot is invalid and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vpn | input | VPN_W | Lookup page number |
| lk_asn | input | ASN_W | Current address-space number |
| lk_hit | output | 1 | Lookup matched |
| lk_idx | output | IDX_W | Matching slot index |
| lk_ppn | output | PPN_W | Physical page number of the match |
| lk_asn_out | output | ASN_W | Stored address-space number of the match |
| lk_global | output | 1 | Global flag of the match |
| ins_en | input | 1 | Insert request |
| ins_vaddr | input | VPN_W+13 | Virtual address to insert |
| ins_ppn | input | PPN_W | Physical page number to store |
| ins_asn | input | ASN_W | Owner address-space number to store |
| ins_global | input | 1 | Global flag to store |
| fl_all | input | 1 | Flush every slot |
| fl_proc | input | 1 | Flush non-global slots |
| fl_page | input | 1 | Flush one page |
| fl_vpn | input | VPN_W | Page number for flush-page |
| fl_asn | input | ASN_W | Address-space number for flush-page |
| nxt_adv | input | 1 | Advance the pointer without writing |
| nxt_idx | output | IDX_W | Current next-to-use pointer |

## Verification
The bench builds the block with DEPTH=6, VPN_W=3, ASN_W=2 and PPN_W=8. With only eight page numbers and four address spaces, random inserts often create duplicate tags, so the lowest-index rule and multi-slot page flushes are exercised often. A depth of six makes the pointer wrap every six inserts, and the wrap from 5 to 0 falls outside a power of two. Random cycles often request several operations together, which exercises the priority order against a bench model.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  localparam int PAGE_SHIFT = 13;

  typedef enum logic [2:0] {
    OP_NONE       = 3'd0,
    OP_FLUSH_ALL  = 3'd1,
    OP_FLUSH_PROC = 3'd2,
    OP_FLUSH_PAGE = 3'd3,
    OP_INSERT     = 3'd4,
    OP_ADVANCE    = 3'd5
  } tlb_op_e;

  // Single operation per cycle, fixed priority.
  function automatic tlb_op_e pick_op(input logic fa, input logic fp,
                                      input logic fg, input logic ins,
                                      input logic adv);
    if (fa)       return OP_FLUSH_ALL;
    else if (fp)  return OP_FLUSH_PROC;
    else if (fg)  return OP_FLUSH_PAGE;
    else if (ins) return OP_INSERT;
    else if (adv) return OP_ADVANCE;
    else          return OP_NONE;
  endfunction

  // Ownership-qualified match of one slot.
  function automatic logic slot_matches(input logic valid, input logic tag_eq,
                                        input logic asn_eq, input logic glb);
    return valid & tag_eq & (glb | asn_eq);
  endfunction

endpackage

// File: rtl/tlb_match_array.sv
module tlb_match_array import tlb_pkg::*; #(
  parameter int DEPTH = 48,
  parameter int VPN_W = 30,
  parameter int ASN_W = 8
) (
  input  logic [DEPTH-1:0]            valid,
  input  logic [DEPTH-1:0][VPN_W-1:0] tags,
  input  logic [DEPTH-1:0][ASN_W-1:0] asns,
  input  logic [DEPTH-1:0]            glbs,
  input  logic [VPN_W-1:0]            req_vpn,
  input  logic [ASN_W-1:0]            req_asn,
  output logic [DEPTH-1:0]            match
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic tag_eq, asn_eq;
    assign tag_eq   = (tags[g] == req_vpn);
    assign asn_eq   = (asns[g] == req_asn);
    assign match[g] = slot_matches(valid[g], tag_eq, asn_eq, glbs[g]);
  end
endmodule

// File: rtl/tlb_lowest_first.sv
module tlb_lowest_first #(
  parameter int DEPTH = 48,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] req,
  output logic             any,
  output logic [IDX_W-1:0] idx,
  output logic [DEPTH-1:0] grant
);
  always_comb begin
    idx   = '0;
    grant = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx   = IDX_W'(i);
        grant = DEPTH'(1) << i;
      end
    end
  end
  assign any = |grant;

  // R2: at most one winner, and it must be a requester
  assert_single_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~req) == '0));
  // R1: a winner exists whenever any slot requests
  assert_any_when_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |-> any);
endmodule

// File: rtl/tlb_nlu_ptr.sv
module tlb_nlu_ptr #(
  parameter int DEPTH = 48,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  function automatic logic [IDX_W-1:0] ptr_next(input logic [IDX_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)     ptr <= '0;
    else if (clear) ptr <= '0;
    else if (step)  ptr <= ptr_next(ptr);
  end

  // R3: wrap from the last slot to zero
  assert_ptr_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear && ptr == LAST) |=> (ptr == '0));
  // R4: clear forces zero
  assert_ptr_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (ptr == '0));
  // R7: no step, no clear -> pointer holds
  assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !step) |=> $stable(ptr));
  // R3: pointer stays in range
  assert_ptr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= LAST);
endmodule

// File: rtl/tlb_assoc.sv
module tlb_assoc import tlb_pkg::*; #(
  parameter int DEPTH = 48,
  parameter int VPN_W = 30,
  parameter int ASN_W = 8,
  parameter int PPN_W = 28,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int VA_W  = VPN_W + PAGE_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [ASN_W-1:0] lk_asn,
  output logic             lk_hit,
  output logic [IDX_W-1:0] lk_idx,
  output logic [PPN_W-1:0] lk_ppn,
  output logic [ASN_W-1:0] lk_asn_out,
  output logic             lk_global,
  input  logic             ins_en,
  input  logic [VA_W-1:0]  ins_vaddr,
  input  logic [PPN_W-1:0] ins_ppn,
  input  logic [ASN_W-1:0] ins_asn,
  input  logic             ins_global,
  input  logic             fl_all,
  input  logic             fl_proc,
  input  logic             fl_page,
  input  logic [VPN_W-1:0] fl_vpn,
  input  logic [ASN_W-1:0] fl_asn,
  input  logic             nxt_adv,
  output logic [IDX_W-1:0] nxt_idx
);
  // Slot storage
  logic [DEPTH-1:0]            valid_q;
  logic [DEPTH-1:0][VPN_W-1:0] tag_q;
  logic [DEPTH-1:0][ASN_W-1:0] asn_q;
  logic [DEPTH-1:0]            glb_q;
  logic [DEPTH-1:0][PPN_W-1:0] ppn_q;

  // Named internal events
  tlb_op_e          op;
  logic [DEPTH-1:0] lk_match;
  logic [DEPTH-1:0] lk_grant;
  logic [DEPTH-1:0] fl_match;
  logic [DEPTH-1:0] below_mask;
  logic [IDX_W-1:0] ptr;
  logic [VPN_W-1:0] ins_vpn;
  logic             do_insert, do_clear_ptr, do_step_ptr;

  assign op           = pick_op(fl_all, fl_proc, fl_page, ins_en, nxt_adv);
  assign do_insert    = (op == OP_INSERT);
  assign do_clear_ptr = (op == OP_FLUSH_ALL);
  assign do_step_ptr  = (op == OP_INSERT) || (op == OP_ADVANCE);
  assign ins_vpn      = ins_vaddr[PAGE_SHIFT +: VPN_W];

  tlb_match_array #(.DEPTH(DEPTH), .VPN_W(VPN_W), .ASN_W(ASN_W)) lk_match_i (
    .valid(valid_q), .tags(tag_q), .asns(asn_q), .glbs(glb_q),
    .req_vpn(lk_vpn), .req_asn(lk_asn), .match(lk_match)
  );

  tlb_match_array #(.DEPTH(DEPTH), .VPN_W(VPN_W), .ASN_W(ASN_W)) fl_match_i (
    .valid(valid_q), .tags(tag_q), .asns(asn_q), .glbs(glb_q),
    .req_vpn(fl_vpn), .req_asn(fl_asn), .match(fl_match)
  );

  tlb_lowest_first #(.DEPTH(DEPTH), .IDX_W(IDX_W)) prio_i (
    .clk(clk), .rst_n(rst_n), .req(lk_match),
    .any(lk_hit), .idx(lk_idx), .grant(lk_grant)
  );

  tlb_nlu_ptr #(.DEPTH(DEPTH), .IDX_W(IDX_W)) ptr_i (
    .clk(clk), .rst_n(rst_n), .clear(do_clear_ptr), .step(do_step_ptr), .ptr(ptr)
  );

  assign nxt_idx = ptr;

  // Output fields: OR of granted slot (all zero on a miss)
  always_comb begin
    lk_ppn     = '0;
    lk_asn_out = '0;
    lk_global  = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (lk_grant[i]) begin
        lk_ppn     = lk_ppn | ppn_q[i];
        lk_asn_out = lk_asn_out | asn_q[i];
        lk_global  = lk_global | glb_q[i];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) below_mask[i] = (IDX_W'(i) < lk_idx);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      tag_q   <= '0;
      asn_q   <= '0;
      glb_q   <= '0;
      ppn_q   <= '0;
    end else begin
      case (op)
        OP_FLUSH_ALL:  valid_q <= '0;
        OP_FLUSH_PROC: valid_q <= valid_q & glb_q;
        OP_FLUSH_PAGE: valid_q <= valid_q & ~fl_match;
        OP_INSERT: begin
          valid_q[ptr] <= 1'b1;
          tag_q[ptr]   <= ins_vpn;
          asn_q[ptr]   <= ins_asn;
          glb_q[ptr]   <= ins_global;
          ppn_q[ptr]   <= ins_ppn;
        end
        default: ;
      endcase
    end
  end

  // R2: no matching slot below the reported index
  assert_lowest_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> ((lk_match & below_mask) == '0));
  // R2: miss drives zero fields
  assert_miss_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_idx == '0 && lk_ppn == '0 && lk_asn_out == '0 && !lk_global));
  // R3: inserted slot is valid next cycle
  assert_insert_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    do_insert |=> valid_q[$past(ptr)]);
  // R4: flush-all empties the array
  assert_flush_all_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_FLUSH_ALL) |=> ($countones(valid_q) == 0));
  // R5: global slots survive a process flush, others do not
  assert_proc_keeps_global_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_FLUSH_PROC) |=> (valid_q == $past(valid_q & glb_q)));
  // R6: matched slots are gone after a page flush
  assert_page_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_FLUSH_PAGE) |=> ((valid_q & $past(fl_match)) == '0));
  // R8: advance never writes a slot
  assert_adv_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ADVANCE) |=> $stable(valid_q));
endmodule

// File: tb/tlb_assoc_tb.sv
module tlb_assoc_tb_top;
  localparam int D = 6, VW = 3, AW = 2, PW = 8, IW = 3, VAW = VW + 13;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [VW-1:0] lk_vpn = '0, fl_vpn = '0;
  logic [AW-1:0] lk_asn = '0, fl_asn = '0, ins_asn = '0, lk_asn_out;
  logic lk_hit, lk_global, ins_en = 0, ins_global = 0;
  logic fl_all = 0, fl_proc = 0, fl_page = 0, nxt_adv = 0;
  logic [IW-1:0] lk_idx, nxt_idx;
  logic [PW-1:0] lk_ppn, ins_ppn = '0;
  logic [VAW-1:0] ins_vaddr = '0;

  always #10 clk = ~clk;  // 50 MHz

  tlb_assoc #(.DEPTH(D), .VPN_W(VW), .ASN_W(AW), .PPN_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_asn(lk_asn), .lk_hit(lk_hit),
    .lk_idx(lk_idx), .lk_ppn(lk_ppn), .lk_asn_out(lk_asn_out), .lk_global(lk_global),
    .ins_en(ins_en), .ins_vaddr(ins_vaddr), .ins_ppn(ins_ppn), .ins_asn(ins_asn),
    .ins_global(ins_global), .fl_all(fl_all), .fl_proc(fl_proc), .fl_page(fl_page),
    .fl_vpn(fl_vpn), .fl_asn(fl_asn), .nxt_adv(nxt_adv), .nxt_idx(nxt_idx)
  );

  // Bench model
  bit          m_v[D];
  bit [VW-1:0] m_tag[D];
  bit [AW-1:0] m_asn[D];
  bit          m_g[D];
  bit [PW-1:0] m_ppn[D];
  int          m_ptr;
  int checks = 0, failures = 0;
  bit done = 0;

  function automatic bit owns(int i, bit [VW-1:0] v, bit [AW-1:0] a);
    if (!m_v[i] || m_tag[i] != v) return 0;
    return m_g[i] || (m_asn[i] == a);
  endfunction

  function automatic int first_owner(bit [VW-1:0] v, bit [AW-1:0] a);
    for (int i = 0; i < D; i++) if (owns(i, v, a)) return i;
    return -1;
  endfunction

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(bit fa, bit fp, bit fg, bit ins, bit adv,
                      bit [VW-1:0] fv, bit [AW-1:0] fa_s,
                      bit [VAW-1:0] iva, bit [PW-1:0] ip, bit [AW-1:0] ia, bit ig,
                      bit [VW-1:0] lv, bit [AW-1:0] la, string tag);
    int w;
    @(negedge clk);
    fl_all = fa; fl_proc = fp; fl_page = fg; ins_en = ins; nxt_adv = adv;
    fl_vpn = fv; fl_asn = fa_s; ins_vaddr = iva; ins_ppn = ip; ins_asn = ia;
    ins_global = ig; lk_vpn = lv; lk_asn = la;
    #2;
    w = first_owner(lv, la);
    chk(tag, "hit", lk_hit, w >= 0);
    chk(tag, "idx", lk_idx, (w >= 0) ? w : 0);
    chk(tag, "ppn", lk_ppn, (w >= 0) ? m_ppn[w] : 0);
    chk(tag, "asn", lk_asn_out, (w >= 0) ? m_asn[w] : 0);
    chk(tag, "global", lk_global, (w >= 0) ? m_g[w] : 0);
    chk("R7", "nxt_idx", nxt_idx, m_ptr);
    @(posedge clk);
    if (fa) begin
      for (int i = 0; i < D; i++) m_v[i] = 0;
      m_ptr = 0;
    end else if (fp) begin
      for (int i = 0; i < D; i++) if (!m_g[i]) m_v[i] = 0;
    end else if (fg) begin
      bit kill[D];
      for (int i = 0; i < D; i++) kill[i] = owns(i, fv, fa_s);
      for (int i = 0; i < D; i++) if (kill[i]) m_v[i] = 0;
    end else if (ins) begin
      m_v[m_ptr] = 1; m_tag[m_ptr] = iva[13 +: VW]; m_asn[m_ptr] = ia;
      m_g[m_ptr] = ig; m_ppn[m_ptr] = ip;
      m_ptr = (m_ptr + 1) % D;
    end else if (adv) begin
      m_ptr = (m_ptr + 1) % D;
    end
  endtask

  function automatic bit [VAW-1:0] va_of(bit [VW-1:0] v);
    return {v, 13'h0A5A};
  endfunction

  task automatic look(bit [VW-1:0] v, bit [AW-1:0] a, string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, v, a, tag);
  endtask

  task automatic put(bit [VW-1:0] v, bit [AW-1:0] a, bit g, bit [PW-1:0] p, string tag);
    step(0, 0, 0, 1, 0, 0, 0, va_of(v), p, a, g, v, a, tag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    int unused;
    unused = $urandom(32'd2024);
    for (int i = 0; i < D; i++) begin
      m_v[i] = 0; m_tag[i] = 0; m_asn[i] = 0; m_g[i] = 0; m_ppn[i] = 0;
    end
    m_ptr = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R9: reset state
    look(3'd0, 2'd0, "R9");
    look(3'd5, 2'd3, "R9");
    // R3: fill all slots, wrap pointer
    for (int i = 0; i < D; i++) put(3'(i), 2'd1, (i % 2) == 0, 8'(8'h10 + i), "R3");
    look(3'd2, 2'd1, "R3");
    // R1: global hit from another space, private miss from another space
    look(3'd2, 2'd3, "R1");
    look(3'd1, 2'd3, "R1");
    look(3'd1, 2'd1, "R1");
    // R2: duplicate tag at slot 0 overwrites and wins over slot 3
    put(3'd3, 2'd1, 1'b0, 8'hEE, "R3");
    look(3'd3, 2'd1, "R2");
    // R6: page flush kills both copies
    step(0, 0, 1, 0, 0, 3'd3, 2'd1, 0, 0, 0, 0, 3'd3, 2'd1, "R6");
    look(3'd3, 2'd1, "R6");
    look(3'd2, 2'd0, "R6");
    // R7: advance only
    step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 3'd4, 2'd1, "R7");
    look(3'd4, 2'd1, "R7");
    // R5: process flush keeps global slots
    step(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3'd5, 2'd1, "R5");
    look(3'd5, 2'd1, "R5");
    look(3'd4, 2'd2, "R5");
    // R8: flush-all with insert in the same cycle, insert ignored
    step(1, 0, 0, 1, 1, 0, 0, va_of(3'd6), 8'h77, 2'd0, 1'b1, 3'd4, 2'd1, "R8");
    look(3'd6, 2'd0, "R8");
    // R8: page flush beats insert
    put(3'd1, 2'd2, 1'b1, 8'h42, "R3");
    step(0, 0, 1, 1, 0, 3'd7, 2'd0, va_of(3'd7), 8'h99, 2'd0, 1'b0, 3'd1, 2'd0, "R8");
    look(3'd7, 2'd0, "R8");
    // R4: flush-all resets pointer
    put(3'd2, 2'd2, 1'b0, 8'h33, "R3");
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3'd2, 2'd2, "R4");
    look(3'd2, 2'd2, "R4");

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      int r;
      bit fa, fp, fg, ins, adv;
      r = $urandom % 40;
      fa = (r == 0); fp = (r >= 1 && r <= 2); fg = (r >= 3 && r <= 6);
      ins = (r >= 7 && r <= 24); adv = (r >= 25 && r <= 27);
      if (($urandom % 8) == 0) ins = 1;
      if (($urandom % 10) == 0) adv = 1;
      step(fa, fp, fg, ins, adv, 3'($urandom), 2'($urandom),
           VAW'($urandom), 8'($urandom), 2'($urandom), 1'($urandom % 4 == 0),
           3'($urandom), 2'($urandom), "R1");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule